// File: doc/BRIEF.md
# Clustered Half-Broadcast Subgroup Unit

This block carries out one clustered broadcast step across a subgroup of lanes. The lanes are divided into equal clusters whose size is chosen per operation by a 2-bit code. In every cluster, one value from the lower half of the cluster is copied into the destinations of the upper half. Repeated steps of this kind are the building block of prefix reductions across a subgroup.

The value copied is taken from the top lane of the lower half. If that lane is inactive, the next active lane below it is used instead. When no lane of the lower half is active, the cluster is left as it was. Lower-half lanes and inactive upper-half lanes always keep their current destination. The whole updated destination vector appears on the outputs one clock after the input strobe, together with a result-valid flag.

Top module: `subgroup_half_bcast`

## Requirements
- R1: The cluster size is 2 shifted left by `size_code` (code 0 gives 2, code 1 gives 4, code 2 gives 8, code 3 gives 16). A size larger than `LANES` is treated as `LANES`.
- R2: In a cluster whose lower-half top lane (index size/2-1 within the cluster) is active, every active upper-half lane receives that lane's source value.
- R3: If the lower-half top lane is inactive, the source is the highest active lane below it in the same lower half.
- R4: If no lane in a cluster's lower half is active, every lane of that cluster keeps its current destination value.
- R5: Lanes in the lower half of any cluster always keep their current destination value.
- R6: An upper-half lane whose active bit is 0 keeps its current destination value.
- R7: Each cluster is handled independently; the mask and data of one cluster do not affect another.
- R8: `out_valid` equals the value `in_valid` had one clock earlier, and `out_data` is the result for the inputs of that same clock; reset clears `out_valid`.
- R9: `out_data` holds its value in every cycle after a cycle with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| size_code | input | 2 | Cluster size code |
| act_mask | input | LANES | Per-lane active bits, bit i for lane i |
| src_data | input | LANES*DW | Per-lane source values, lane i at bits [i*DW +: DW] |
| dst_data | input | LANES*DW | Per-lane current destination values, same packing |
| out_valid | output | 1 | Registered result valid |
| out_data | output | LANES*DW | Registered updated destination vector |

## Verification
The bench goes after the fallback search: masks that knock out the preferred lane and some lanes below it, where a design that picked the lowest active lane, or one that took the preferred lane regardless of its mask, would copy the wrong value. Masks that empty a whole lower half check that such a cluster stays untouched, rather than copying a stale or zero value. Masks with inactive upper lanes check that the design does not write them. All four sizes are tried with two clusters that see different patterns, so a size decode that is off by one, or a search that runs across cluster edges, gives wrong lanes. Hold cycles with the strobe low show that the output register loads only on a strobe.

// File: rtl/bcast_pkg.sv
package bcast_pkg;
  // Number of distinct cluster sizes selectable by the 2-bit code.
  localparam int NUM_SIZES = 4;

  // Cluster size selected by a given code.
  function automatic int size_of_code(input int code);
    return 2 << code;
  endfunction
endpackage

// File: rtl/bcast_size_decode.sv
module bcast_size_decode #(
  parameter int LANES = 16
) (
  input  logic [1:0]                     size_code,
  output logic [bcast_pkg::NUM_SIZES-1:0] size_sel
);
  // Largest code whose cluster still fits in the subgroup.
  localparam int MAX_CODE = $clog2(LANES) - 1;
  localparam int CAP = (MAX_CODE > bcast_pkg::NUM_SIZES - 1) ? bcast_pkg::NUM_SIZES - 1 : MAX_CODE;

  logic [1:0] eff_code;

  always_comb begin
    if (int'(size_code) > CAP) eff_code = 2'(CAP);
    else                       eff_code = size_code;
    size_sel = '0;
    size_sel[eff_code] = 1'b1;
  end
endmodule

// File: rtl/bcast_cluster_stage.sv
module bcast_cluster_stage #(
  parameter int LANES = 16,
  parameter int DW    = 32,
  parameter int CSIZE = 8
) (
  input  logic [LANES-1:0]    act_mask,
  input  logic [LANES*DW-1:0] src_data,
  input  logic [LANES*DW-1:0] dst_data,
  output logic [LANES*DW-1:0] res_data
);
  localparam int NCLUST = LANES / CSIZE;
  localparam int HALF   = CSIZE / 2;

  for (genvar c = 0; c < NCLUST; c++) begin : g_clust
    localparam int BASE = c * CSIZE;
    logic          found;
    logic [DW-1:0] pick;

    // Ascending scan: the last active lower lane seen is the highest one.
    always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int j = 0; j < HALF; j++) begin
        if (act_mask[BASE + j]) begin
          found = 1'b1;
          pick  = src_data[(BASE + j)*DW +: DW];
        end
      end
    end

    for (genvar l = 0; l < CSIZE; l++) begin : g_lane
      localparam int LN = BASE + l;
      if (l < HALF) begin : g_low
        assign res_data[LN*DW +: DW] = dst_data[LN*DW +: DW];
      end else begin : g_high
        assign res_data[LN*DW +: DW] =
          (found && act_mask[LN]) ? pick : dst_data[LN*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/subgroup_half_bcast.sv
module subgroup_half_bcast #(
  parameter int LANES = 16,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          size_code,
  input  logic [LANES-1:0]    act_mask,
  input  logic [LANES*DW-1:0] src_data,
  input  logic [LANES*DW-1:0] dst_data,
  output logic                out_valid,
  output logic [LANES*DW-1:0] out_data
);
  import bcast_pkg::*;

  logic [NUM_SIZES-1:0] size_sel;
  logic [LANES*DW-1:0]  stage_res [NUM_SIZES];
  logic [LANES*DW-1:0]  next_res;
  logic [LANES*DW-1:0]  data_d;
  logic                 valid_d;

  bcast_size_decode #(.LANES(LANES)) u_decode (
    .size_code (size_code),
    .size_sel  (size_sel)
  );

  // One broadcast network per cluster size that fits in the subgroup.
  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    localparam int CS = size_of_code(k);
    if (CS <= LANES) begin : g_fit
      bcast_cluster_stage #(.LANES(LANES), .DW(DW), .CSIZE(CS)) u_stage (
        .act_mask (act_mask),
        .src_data (src_data),
        .dst_data (dst_data),
        .res_data (stage_res[k])
      );
    end else begin : g_none
      assign stage_res[k] = '0;
    end
  end

  always_comb begin
    next_res = dst_data;
    for (int k = 0; k < NUM_SIZES; k++) begin
      if (size_sel[k]) next_res = stage_res[k];
    end
  end

  // Next-state logic with explicit load enable.
  always_comb begin
    valid_d = in_valid;
    data_d  = in_valid ? next_res : out_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_d;
  end

  always_ff @(posedge clk) begin
    out_data <= data_d;
  end

  // R8: result strobe trails the input strobe by exactly one clock.
  assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));

  // R9: the result register holds when no operation was issued.
  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  // R5: lane 0 lies in a lower half for every size.
  assert_lane0_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_data[DW-1:0] == $past(dst_data[DW-1:0])));

  // R2: size 2 with both lanes active copies lane 0 into lane 1.
  assert_pair_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_code == 2'd0 && act_mask[0] && act_mask[1]) |=>
      (out_data[DW +: DW] == $past(src_data[DW-1:0])));

  // R6: an inactive lane is never written.
  for (genvar i = 0; i < LANES; i++) begin : g_chk
    assert_idle_lane_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !act_mask[i]) |=>
        (out_data[i*DW +: DW] == $past(dst_data[i*DW +: DW])));
  end
endmodule

// File: tb/tb_subgroup_half_bcast.sv
module tb_subgroup_half_bcast;
  localparam int LANES = 16;
  localparam int DW    = 32;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  // Stimulus table: {size code, active mask, requirement tag number}.
  typedef struct packed {
    logic [1:0]  code;
    logic [15:0] mask;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{2'd2, 16'hFFFF, 8'd2},  // R2: size 8, lanes 4-7 get lane 3, 12-15 get 11
    '{2'd2, 16'hFFF3, 8'd3},  // R3: lanes 2,3 off, lanes 4-7 get lane 1
    '{2'd0, 16'hFFFF, 8'd1},  // R1: size 2
    '{2'd1, 16'hFFFF, 8'd1},  // R1: size 4
    '{2'd3, 16'hFFFF, 8'd1},  // R1: size 16
    '{2'd3, 16'h00FF, 8'd6},  // R6: all upper lanes off, nothing written
    '{2'd2, 16'hFFF0, 8'd4},  // R4/R7: cluster 0 lower empty, cluster 1 normal
    '{2'd1, 16'h5555, 8'd6},  // R6/R3: alternating lanes
    '{2'd3, 16'h8001, 8'd3},  // R3: only lane 0 below, lane 15 gets lane 0
    '{2'd0, 16'hAAAA, 8'd4}   // R4: size 2, every lower lane off
  };

  logic                clk;
  logic                rst_n;
  logic                in_valid;
  logic [1:0]          size_code;
  logic [LANES-1:0]    act_mask;
  logic [LANES*DW-1:0] src_data;
  logic [LANES*DW-1:0] dst_data;
  logic                out_valid;
  logic [LANES*DW-1:0] out_data;

  int checks;
  int errors;

  subgroup_half_bcast #(.LANES(LANES), .DW(DW)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .size_code (size_code),
    .act_mask  (act_mask),
    .src_data  (src_data),
    .dst_data  (dst_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model written from the requirements, lane by lane.
  function automatic logic [LANES*DW-1:0] model(input logic [1:0] code,
      input logic [LANES-1:0] m, input logic [LANES*DW-1:0] s,
      input logic [LANES*DW-1:0] d);
    logic [LANES*DW-1:0] r;
    int cs, base, pos, half;
    bit hit;
    r = d;
    cs = 2 << code;
    if (cs > LANES) cs = LANES;
    half = cs / 2;
    for (int l = 0; l < LANES; l++) begin
      base = l - (l % cs);
      pos  = l % cs;
      if (pos >= half && m[l]) begin
        hit = 0;
        for (int j = half - 1; j >= 0; j--) begin
          if (!hit && m[base + j]) begin
            hit = 1;
            r[l*DW +: DW] = s[(base + j)*DW +: DW];
          end
        end
      end
    end
    return r;
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < LANES; i++) begin
      src_data[i*DW +: DW] = DW'(32'h5A000000 + seed*32'h10000 + i);
      dst_data[i*DW +: DW] = DW'(32'hD0000000 + seed*32'h10000 + i*3);
    end
  endtask

  task automatic check_vec(input string tag, input logic [LANES*DW-1:0] exp);
    checks++;
    if (out_data !== exp) begin
      errors++;
      for (int i = 0; i < LANES; i++) begin
        if (out_data[i*DW +: DW] !== exp[i*DW +: DW]) begin
          $display("FAIL %s lane %0d: actual %h expected %h", tag, i,
                   out_data[i*DW +: DW], exp[i*DW +: DW]);
          break;
        end
      end
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // One operation: drive at falling edge, sample at the following falling edge.
  task automatic run_op(input logic [1:0] code, input logic [LANES-1:0] m,
                        input int seed, input string tag);
    logic [LANES*DW-1:0] exp;
    size_code = code;
    act_mask  = m;
    fill(seed);
    exp = model(code, m, src_data, dst_data);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit({tag, " valid"}, out_valid, 1'b1);
    check_vec(tag, exp);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [LANES*DW-1:0] held;
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    size_code = 2'd0;
    act_mask = '0;
    src_data = '0;
    dst_data = '0;
    repeat (3) @(negedge clk);
    // R8: reset state of the result strobe.
    check_bit("R8 reset", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R8 idle after reset", out_valid, 1'b0);

    for (int v = 0; v < NVEC; v++) begin
      run_op(VECS[v].code, VECS[v].mask, v + 1, $sformatf("R%0d vec %0d", VECS[v].req, v));
    end

    // R8: strobe drops one clock after a single pulse.
    @(negedge clk);
    check_bit("R8 strobe drop", out_valid, 1'b0);

    // R9: inputs change with strobe low, output holds.
    held = out_data;
    size_code = 2'd0;
    act_mask = '1;
    fill(77);
    repeat (3) @(negedge clk);
    check_vec("R9 hold", held);

    // R7: distinct cluster patterns at size 4.
    run_op(2'd1, 16'b1011_0110_0001_1110, 40, "R7 mixed clusters");
    // R3: fallback over several inactive lanes at size 16.
    run_op(2'd3, 16'hF024, 41, "R3 deep fallback");
    // R5: lower halves untouched even with full mask at size 8.
    run_op(2'd2, 16'hFFFF, 42, "R5 lower kept");

    // R8: back-to-back strobes give back-to-back results.
    size_code = 2'd0; act_mask = '1; fill(50);
    in_valid = 1'b1;
    @(negedge clk);
    check_vec("R8 b2b first", model(2'd0, '1, src_data, dst_data));
    size_code = 2'd3; act_mask = 16'h0102; fill(51);
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R8 b2b valid", out_valid, 1'b1);
    check_vec("R8 b2b second", model(2'd3, 16'h0102, src_data, dst_data));

    // R8: reset mid-run clears the strobe.
    in_valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_bit("R8 async clear", out_valid, 1'b0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule